// File: doc/BRIEF.md
# Triple-Channel Match Timer

This peripheral holds three independent counters behind a small word-addressed register bus. Every channel has a count register, a reload value and two compare values. While it is running, a channel steps once per cycle of the main clock, or once per rising edge of an external clock input. By default it counts down. When it passes its terminal value it takes the reload value again. Software can arm a timeout by writing a compare value some distance from the current count. It can also use one channel as a free-running time base by giving it an all-ones reload value.

A single control word holds, for each channel, a run bit, a clock-source bit and an overflow-interrupt enable. A parameter selects one of two packings for this word. The dense packing uses three bits per channel and adds a global count-up bit. The aligned packing places each channel on a four-bit boundary and has no count-up bit. Compare hits and overflows set sticky status bits. These bits are cleared by writing ones, and they are combined through a mask into one interrupt line.

Top module: `tri_match_timer`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: Addresses are per channel n (n = 0, 1, 2 at base 0x00, 0x10, 0x20): count +0x0, reload +0x4, compare A +0x8, compare B +0xC. Control is at 0x30, status at 0x34 and mask at 0x38. The reload, compare and mask registers read back what was written, limited to their implemented bits. The mask has 9 bits.
- R3: A write to a count register appears in that register on the clock edge of the write, and it replaces any step in that cycle.
- R4: A running channel on the main clock counts down by one per cycle. A channel whose run bit is clear holds its count.
- R5: A down-counting channel at zero takes its reload value on its next step and sets its overflow status bit.
- R6: In the dense packing, control bit 9 makes all channels count up. A channel at all ones then takes its reload value on its next step and sets its overflow status bit.
- R7: When a step brings the count equal to compare A or compare B, the matching status bit is set on that same edge.
- R8: Status bit 3n is compare A, bit 3n+1 is compare B and bit 3n+2 is overflow of channel n. Bits stay set until a one is written to them, and writing ones clears only those bits.
- R9: With its clock-source bit set, a running channel steps exactly once per rising edge of `ext_clk`. The input is passed through two synchronizing flops.
- R10: `irq` is high while any status bit is set and its mask bit is clear. An overflow bit counts only when that channel's overflow-interrupt enable is set.
- R11: In the dense packing (LAYOUT=0), channel n uses control bits 3n (run), 3n+1 (clock source) and 3n+2 (overflow enable), and the writable mask is 0x3FF. In the aligned packing (LAYOUT=1) these fields are at bits 4n, 4n+1 and 4n+2, the writable mask is 0x777, and bits 3 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk | input | 1 | External count source, asynchronous |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W (8) | Byte address, word aligned |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write takes effect on the clock edge that ends the access. Read data and `irq` follow combinationally from the registers, so the bench drives and samples at the falling edge. After a write it reads back before the next rising edge. A count step lands one edge after the edge that enables the channel, and a compare or overflow status bit is set on the same edge as the count step that causes it. The bench waits a known number of falling edges and compares against a count it works out from those rules. A rising edge on `ext_clk` produces its step three edges later, after two synchronizer stages and an edge detector. The bench therefore holds each external level for three cycles and allows three more cycles of margin before it reads the count.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

  localparam int NUM_CH     = 3;
  localparam int FLD_PER_CH = 3;
  localparam int STAT_W     = NUM_CH * FLD_PER_CH;
  localparam int CTRL_W     = 11;
  localparam int UP_BIT     = 9;

  // register select within a block (address bits 3:2)
  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_LOAD = 2'd1;
  localparam logic [1:0] SEL_CMPA = 2'd2;
  localparam logic [1:0] SEL_CMPB = 2'd3;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
  localparam logic [1:0] BLK_MISC = 2'd3;

  typedef struct packed {
    logic run;
    logic ext_sel;
    logic ovf_ie;
  } ch_cfg_t;

  function automatic logic [CTRL_W-1:0] ctrl_wmask(input int layout);
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int f = 0; f < FLD_PER_CH; f++) begin
        m[((layout == 0) ? FLD_PER_CH : 4) * c + f] = 1'b1;
      end
    end
    if (layout == 0) m[UP_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/tmt_ext_sync.sv
module tmt_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic tick
);

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tick = s2_q & ~s3_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R9

endmodule

// File: rtl/tmt_channel.sv
module tmt_channel
  import tmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ch_cfg_t          cfg,
  input  logic             count_up,
  input  logic             ext_tick,
  input  logic             wr_cnt,
  input  logic             wr_load,
  input  logic             wr_cmpa,
  input  logic             wr_cmpb,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] cmpa,
  output logic [CNT_W-1:0] cmpb,
  output logic             ev_cmpa,
  output logic             ev_cmpb,
  output logic             ev_ovf
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_adv;
  logic [CNT_W-1:0] load_q, cmpa_q, cmpb_q;
  logic             step, at_end, src_tick;

  always_comb begin
    src_tick = cfg.ext_sel ? ext_tick : 1'b1;
    step     = cfg.run & src_tick & ~wr_cnt;
    at_end   = count_up ? (cnt_q == ONES) : (cnt_q == '0);
    if (at_end)        cnt_adv = load_q;
    else if (count_up) cnt_adv = cnt_q + ONE;
    else               cnt_adv = cnt_q - ONE;
    cnt_d = cnt_q;
    if (wr_cnt)    cnt_d = wdata;
    else if (step) cnt_d = cnt_adv;
  end

  assign ev_ovf  = step & at_end;
  assign ev_cmpa = step & (cnt_adv == cmpa_q);
  assign ev_cmpb = step & (cnt_adv == cmpb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_load) load_q <= wdata;
      if (wr_cmpa) cmpa_q <= wdata;
      if (wr_cmpb) cmpb_q <= wdata;
    end
  end

  assign cnt  = cnt_q;
  assign load = load_q;
  assign cmpa = cmpa_q;
  assign cmpb = cmpb_q;

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata)); // R3

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.run && !wr_cnt) |=> $stable(cnt_q)); // R4

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && !cfg.ext_sel && !wr_cnt && !count_up && cnt_q == '0)
      |=> cnt_q == $past(load_q)); // R5

endmodule

// File: rtl/tmt_irq.sv
module tmt_irq #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_req,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic [N-1:0] gate,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq
);

  logic [N-1:0] stat_q, stat_d, mask_q;

  always_comb begin
    stat_d = (stat_q & ~clr_req) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = |(stat_q & ~mask_q & gate);

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req & ~set_ev) != '0) |=> ((stat_q & $past(clr_req & ~set_ev)) == '0)); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr_req)) == '0)); // R8

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq); // R10

endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
  import tmt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam logic [CTRL_W-1:0] CTRL_WMASK = ctrl_wmask(LAYOUT);
  localparam int FSTRIDE = (LAYOUT == 0) ? FLD_PER_CH : 4;

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  // address decode
  logic       addr_ok, wr;
  logic [1:0] blk, rsel;
  assign blk     = bus_addr[5:4];
  assign rsel    = bus_addr[3:2];
  assign addr_ok = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:6] == '0);
  assign wr      = bus_en & bus_we & addr_ok;

  logic ctrl_we, stat_we, mask_we;
  assign ctrl_we = wr && (blk == BLK_MISC) && (rsel == SEL_CTRL);
  assign stat_we = wr && (blk == BLK_MISC) && (rsel == SEL_STAT);
  assign mask_we = wr && (blk == BLK_MISC) && (rsel == SEL_MASK);

  // control register
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = bus_wdata[CTRL_W-1:0] & CTRL_WMASK;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  logic count_up;
  generate
    if (LAYOUT == 0) begin : g_dense
      assign count_up = ctrl_q[UP_BIT];
    end else begin : g_aligned
      assign count_up = 1'b0;
    end
  endgenerate

  // external clock source
  logic ext_tick;
  tmt_ext_sync u_ext_sync (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .ext_in (ext_clk),
    .tick   (ext_tick)
  );

  // channels
  ch_cfg_t          cfg_a  [NUM_CH];
  logic [CNT_W-1:0] cnt_a  [NUM_CH];
  logic [CNT_W-1:0] load_a [NUM_CH];
  logic [CNT_W-1:0] cmpa_a [NUM_CH];
  logic [CNT_W-1:0] cmpb_a [NUM_CH];
  logic [STAT_W-1:0] set_ev, gate;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int B = FSTRIDE * i;
      logic ch_wr;
      assign ch_wr = wr && (blk == 2'(i));

      assign cfg_a[i].run     = ctrl_q[B];
      assign cfg_a[i].ext_sel = ctrl_q[B+1];
      assign cfg_a[i].ovf_ie  = ctrl_q[B+2];

      assign gate[FLD_PER_CH*i]   = 1'b1;
      assign gate[FLD_PER_CH*i+1] = 1'b1;
      assign gate[FLD_PER_CH*i+2] = cfg_a[i].ovf_ie;

      tmt_channel #(.CNT_W(CNT_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_i_n),
        .cfg      (cfg_a[i]),
        .count_up (count_up),
        .ext_tick (ext_tick),
        .wr_cnt   (ch_wr && (rsel == SEL_CNT)),
        .wr_load  (ch_wr && (rsel == SEL_LOAD)),
        .wr_cmpa  (ch_wr && (rsel == SEL_CMPA)),
        .wr_cmpb  (ch_wr && (rsel == SEL_CMPB)),
        .wdata    (bus_wdata),
        .cnt      (cnt_a[i]),
        .load     (load_a[i]),
        .cmpa     (cmpa_a[i]),
        .cmpb     (cmpb_a[i]),
        .ev_cmpa  (set_ev[FLD_PER_CH*i]),
        .ev_cmpb  (set_ev[FLD_PER_CH*i+1]),
        .ev_ovf   (set_ev[FLD_PER_CH*i+2])
      );
    end
  endgenerate

  // interrupt aggregation
  logic [STAT_W-1:0] status, mask, clr_req;
  assign clr_req = stat_we ? bus_wdata[STAT_W-1:0] : '0;

  tmt_irq #(.N(STAT_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .set_ev     (set_ev),
    .clr_req    (clr_req),
    .mask_we    (mask_we),
    .mask_wdata (bus_wdata[STAT_W-1:0]),
    .gate       (gate),
    .status     (status),
    .mask       (mask),
    .irq        (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      if (blk == BLK_MISC) begin
        case (rsel)
          SEL_CTRL: bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
          SEL_STAT: bus_rdata = {{(CNT_W-STAT_W){1'b0}}, status};
          SEL_MASK: bus_rdata = {{(CNT_W-STAT_W){1'b0}}, mask};
          default:  bus_rdata = '0;
        endcase
      end else begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (blk == 2'(i)) begin
            case (rsel)
              SEL_CNT:  bus_rdata = cnt_a[i];
              SEL_LOAD: bus_rdata = load_a[i];
              SEL_CMPA: bus_rdata = cmpa_a[i];
              default:  bus_rdata = cmpb_a[i];
            endcase
          end
        end
      end
    end
  end

  AST_CTRL_IMPL_BITS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ctrl_q & ~CTRL_WMASK) == '0); // R11

  AST_MASKED_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!cfg_a[0].ovf_ie && status == 9'h004) |-> !irq); // R10

endmodule

// File: tb/tri_match_timer_tb.sv
`timescale 1ns/1ps
module tri_match_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_clk;
  logic        en_a, en_b, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, rd_a, rd_b;
  logic        irq_a, irq_b;
  int          checks = 0;
  int          fails  = 0;

  always #4 clk = ~clk;

  tri_match_timer #(.CNT_W(32), .ADDR_W(8), .LAYOUT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .bus_en(en_a), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a), .irq(irq_a));

  tri_match_timer #(.CNT_W(32), .ADDR_W(8), .LAYOUT(1)) u_dut_al (
    .clk(clk), .rst_n(rst_n), .ext_clk(1'b0), .bus_en(en_b), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b), .irq(irq_b));

  // {addr, write data, expected read}
  localparam logic [71:0] VEC [13] = '{
    {8'h04, 32'hAAAA5555, 32'hAAAA5555},
    {8'h08, 32'h12345678, 32'h12345678},
    {8'h0C, 32'h0BADF00D, 32'h0BADF00D},
    {8'h14, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {8'h18, 32'h00000003, 32'h00000003},
    {8'h1C, 32'h80000000, 32'h80000000},
    {8'h24, 32'h13579BDF, 32'h13579BDF},
    {8'h28, 32'hDEADBEEF, 32'hDEADBEEF},
    {8'h2C, 32'h00C0FFEE, 32'h00C0FFEE},
    {8'h38, 32'hFFFFFFFF, 32'h000001FF},
    {8'h38, 32'h00000000, 32'h00000000},
    {8'h30, 32'hFFFFFFFF, 32'h000003FF},
    {8'h30, 32'h00000000, 32'h00000000}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bw(input bit to_b, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    en_a = !to_b; en_b = to_b; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    en_a = 1'b0; en_b = 1'b0; bus_we = 1'b0;
  endtask

  task automatic br(input bit from_b, input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = from_b ? rd_b : rd_a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; ext_clk = 1'b0; en_a = 1'b0; en_b = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    nxt(5);
    rst_n = 1'b1;
    nxt(4);

    // R1: reset state
    for (int a = 0; a < 15; a++) begin
      br(0, 8'(a * 4), v);
      chk("R1", $sformatf("reset read %h", a * 4), v, 32'h0);
    end
    chk("R1", "irq after reset", {31'b0, irq_a}, 32'h0);

    // R2: register table
    for (int k = 0; k < 13; k++) begin
      bw(0, VEC[k][71:64], VEC[k][63:32]);
      br(0, VEC[k][71:64], v);
      chk(k >= 11 ? "R11" : "R2", $sformatf("table %0d", k), v, VEC[k][31:0]);
    end

    // R3, R4
    bw(0, 8'h30, 32'h0);
    bw(0, 8'h00, 32'd100);
    br(0, 8'h00, v); chk("R3", "count write", v, 32'd100);
    nxt(5);
    br(0, 8'h00, v); chk("R4", "disabled holds", v, 32'd100);
    bw(0, 8'h04, 32'd20);
    bw(0, 8'h30, 32'h1);
    br(0, 8'h00, v); chk("R4", "no step on enable edge", v, 32'd100);
    nxt(10);
    br(0, 8'h00, v); chk("R4", "down count", v, 32'd90);

    // R5 and overflow gating (R10)
    bw(0, 8'h34, 32'h1FF);
    bw(0, 8'h00, 32'd2);
    br(0, 8'h00, v); chk("R3", "overwrite while running", v, 32'd2);
    nxt(3);
    br(0, 8'h00, v); chk("R5", "reload after zero", v, 32'd20);
    br(0, 8'h34, v); chk("R5", "overflow status", v, 32'h004);
    chk("R10", "ovf without enable", {31'b0, irq_a}, 32'h0);
    bw(0, 8'h30, 32'h5);
    chk("R10", "ovf with enable", {31'b0, irq_a}, 32'h1);
    bw(0, 8'h38, 32'h004);
    chk("R10", "ovf masked", {31'b0, irq_a}, 32'h0);
    bw(0, 8'h38, 32'h0);
    bw(0, 8'h34, 32'h004);
    br(0, 8'h34, v); chk("R8", "w1c overflow", v, 32'h0);
    chk("R10", "irq drops after clear", {31'b0, irq_a}, 32'h0);

    // R7, R8
    bw(0, 8'h30, 32'h0);
    bw(0, 8'h08, 32'd45);
    bw(0, 8'h0C, 32'd40);
    bw(0, 8'h00, 32'd50);
    bw(0, 8'h34, 32'h1FF);
    bw(0, 8'h30, 32'h1);
    nxt(5);
    br(0, 8'h00, v); chk("R7", "count at compare A", v, 32'd45);
    br(0, 8'h34, v); chk("R7", "compare A status", v, 32'h001);
    nxt(5);
    br(0, 8'h34, v); chk("R7", "compare B status", v, 32'h003);
    chk("R10", "match irq unmasked", {31'b0, irq_a}, 32'h1);
    bw(0, 8'h34, 32'h001);
    br(0, 8'h34, v); chk("R8", "partial w1c", v, 32'h002);
    bw(0, 8'h34, 32'h002);
    chk("R10", "irq low when clear", {31'b0, irq_a}, 32'h0);

    // R6: count up
    bw(0, 8'h30, 32'h0);
    bw(0, 8'h00, 32'hFFFFFFFE);
    bw(0, 8'h04, 32'd7);
    bw(0, 8'h34, 32'h1FF);
    bw(0, 8'h30, 32'h201);
    nxt(1);
    br(0, 8'h00, v); chk("R6", "count up", v, 32'hFFFFFFFF);
    nxt(1);
    br(0, 8'h00, v); chk("R6", "reload past ones", v, 32'd7);
    br(0, 8'h34, v); chk("R6", "up overflow status", v, 32'h004);
    nxt(1);
    br(0, 8'h00, v); chk("R6", "up after reload", v, 32'd8);

    // R9: external source on channel 1 (base 0x10)
    bw(0, 8'h30, 32'h0);
    bw(0, 8'h10, 32'd1000);
    bw(0, 8'h30, 32'h018);
    nxt(4);
    br(0, 8'h10, v); chk("R9", "no ext edge holds", v, 32'd1000);
    for (int p = 0; p < 5; p++) begin
      ext_clk = 1'b1; nxt(3);
      ext_clk = 1'b0; nxt(3);
    end
    nxt(3);
    br(0, 8'h10, v); chk("R9", "five ext edges", v, 32'd995);

    // R11: aligned packing
    bw(1, 8'h30, 32'hFFFFFFFF);
    br(1, 8'h30, v); chk("R11", "aligned writable bits", v, 32'h777);
    bw(1, 8'h30, 32'h0);
    bw(1, 8'h10, 32'd10);
    bw(1, 8'h30, 32'h008);
    nxt(4);
    br(1, 8'h10, v); chk("R11", "bit3 unused", v, 32'd10);
    bw(1, 8'h30, 32'h010);
    nxt(4);
    br(1, 8'h10, v); chk("R11", "aligned run bit", v, 32'd6);

    summary();
    $finish;
  end

endmodule